// File: doc/BRIEF.md
# Non-uniform piecewise-linear sine evaluator

This block gives an approximation of sin(πx/2) for an unsigned fractional input x in [0,1). That range is the first quadrant of a sine period. The quadrant is covered by ten straight-line pieces of unequal width. Pieces are narrow where the curve bends sharply, near the top of the quadrant, and wide where the curve is nearly straight, near zero. The boundaries between pieces are elaboration-time constants.

A bank of unsigned magnitude comparators tests x against every inner boundary at the same time. The comparator outputs form a thermometer code, and a priority multiplexer turns that code into a piece number. The piece number reads a slope from one constant table and an intercept from a second one. The block then forms slope·x + intercept. A register follows the multiplier, and the rounded product and intercept are added after it.

The evaluator is meant to sit behind a phase accumulator and a quadrant-folding stage. Those stages, and the offline fitting of the lines, lie outside this block. Each result carries a valid flag that follows the input flag, and the selected piece number is brought out alongside the value.

Top module: `pwl_sine_eval`

## Requirements
- R1: With the default OUT_REG = 0, an input accepted with in_valid high at a rising clock edge yields out_valid high after that same edge, which is one cycle of latency. Inputs on consecutive cycles give outputs on consecutive cycles.
- R2: Each comparator outputs 1 while x is strictly below its boundary and 0 once x equals or exceeds it. At x = B−1 the piece is the one below boundary B, and at x = B it is the one above.
- R3: out_seg is a 0-based piece number in 0..9. It equals the count of inner boundaries that are less than or equal to x. An all-ones comparator vector gives 0, and an all-zeros vector gives 9.
- R4: For the default 10-bit input, in units of 1/1024, the nine inner boundaries are 205, 334, 444, 543, 636, 724, 809, 892 and 974.
- R5: For every 10-bit input, |out_y/65536 − sin(πx/2048)| ≤ 0.0015.
- R6: out_y is unsigned, with 1 integer bit and OF = 16 fraction bits. The sum of the rounded product and the rounded intercept never carries beyond that width.
- R7: x = 0 yields out_y = 65 exactly. This is the intercept of the first piece rounded to 16 fraction bits, with a zero product.
- R8: A cycle with in_valid low yields out_valid low one cycle later.
- R9: While rst_n is low, and until the first valid input has been accepted, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | in_x carries an argument this cycle |
| in_x | input | XW (10) | Unsigned argument, all bits fractional |
| out_valid | output | 1 | out_y and out_seg carry a result |
| out_y | output | OF+1 (17) | Approximated sine, 1 integer bit and OF fraction bits |
| out_seg | output | clog2(10) (4) | Piece number used for this result |

## Verification
The embedded properties check three things on every cycle. The comparator vector always has thermometer shape. The piece number stays inside the table. The valid flag tracks the input flag with the stated delay, and the final sum never needs a carry bit. Accuracy against the true sine, the exact piece chosen on each side of every boundary, and the exact value at zero depend on the constant tables. Only the bench's exhaustive sweep over all 1024 inputs and its randomly gapped traffic can show these.

// File: rtl/pwl_sine_pkg.sv
package pwl_sine_pkg;

   // number of linear pieces covering the quadrant
   localparam int SEGS = 10;

   // inner boundaries, as fractions of the quadrant (SEGS-1 values)
   function automatic real edge_r(input int k);
      case (k)
         0:       return 0.2001953125;
         1:       return 0.326171875;
         2:       return 0.43359375;
         3:       return 0.5302734375;
         4:       return 0.62109375;
         5:       return 0.70703125;
         6:       return 0.7900390625;
         7:       return 0.87109375;
         default: return 0.951171875;
      endcase
   endfunction

   // per-piece slope
   function automatic real slope_r(input int k);
      case (k)
         0:       return 1.54503497834031;
         1:       return 1.43612208005773;
         2:       return 1.29779670692432;
         3:       return 1.14069314244100;
         4:       return 0.970322027885993;
         5:       return 0.790355834163542;
         6:       return 0.604027272905406;
         7:       return 0.412863639934916;
         8:       return 0.218415511777311;
         default: return 0.0602097594473886;
      endcase
   endfunction

   // per-piece intercept
   function automatic real icpt_r(input int k);
      case (k)
         0:       return 0.000990880661757787;
         1:       return 0.0227876190983088;
         2:       return 0.0679214996797700;
         3:       return 0.136030419000189;
         4:       return 0.226383524844325;
         5:       return 0.338143580690051;
         6:       return 0.46985;
         7:       return 0.620903909462291;
         8:       return 0.790288325648528;
         default: return 0.940157596611038;
      endcase
   endfunction

endpackage

// File: rtl/pwl_seg_locate.sv
module pwl_seg_locate #(
   parameter int XW   = 10,
   parameter int NSEG = 10,
   parameter int IW   = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [XW-1:0] x_i,
   output logic [IW-1:0] seg_o
);
   localparam real SCALE = 2.0 ** XW;

   logic [NSEG-2:0] below;

   generate
      if (NSEG < 2) begin : g_bad_nseg
         $error("pwl_seg_locate: at least two pieces are required");
      end
      if ((1 << IW) < NSEG) begin : g_bad_iw
         $error("pwl_seg_locate: index width too small");
      end
      for (genvar k = 0; k < NSEG - 1; k++) begin : g_cmp
         localparam logic [XW:0] EDGE_Q =
            (XW+1)'($rtoi(pwl_sine_pkg::edge_r(k) * SCALE + 0.5));
         assign below[k] = ({1'b0, x_i} < EDGE_Q);
      end
   endgenerate

   // priority mux: lowest comparator still high marks the piece
   always_comb begin
      seg_o = IW'(NSEG - 1);
      for (int k = NSEG - 2; k >= 0; k--) begin
         if (below[k]) seg_o = IW'(k);
      end
   end

   // R2
   therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |-> (((~below) & ((~below) + 1'b1)) == '0));

   // R3
   seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |-> (seg_o < IW'(NSEG)));

endmodule

// File: rtl/pwl_coef_rom.sv
module pwl_coef_rom #(
   parameter int NSEG = 10,
   parameter int IW   = 4,
   parameter int CF   = 17,
   parameter int CW   = CF + 1
) (
   input  logic [IW-1:0] seg_i,
   output logic [CW-1:0] slope_o,
   output logic [CW-1:0] icpt_o
);
   localparam real SCALE = 2.0 ** CF;

   logic [CW-1:0] slope_tab [NSEG];
   logic [CW-1:0] icpt_tab  [NSEG];

   generate
      if (CW != CF + 1) begin : g_bad_cw
         $error("pwl_coef_rom: coefficients need exactly one integer bit");
      end
      for (genvar k = 0; k < NSEG; k++) begin : g_ent
         localparam logic [CW-1:0] A_Q =
            CW'($rtoi(pwl_sine_pkg::slope_r(k) * SCALE + 0.5));
         localparam logic [CW-1:0] B_Q =
            CW'($rtoi(pwl_sine_pkg::icpt_r(k) * SCALE + 0.5));
         assign slope_tab[k] = A_Q;
         assign icpt_tab[k]  = B_Q;
      end
   endgenerate

   always_comb begin
      slope_o = '0;
      icpt_o  = '0;
      for (int k = 0; k < NSEG; k++) begin
         if (seg_i == IW'(k)) begin
            slope_o = slope_tab[k];
            icpt_o  = icpt_tab[k];
         end
      end
   end

endmodule

// File: rtl/pwl_sine_eval.sv
module pwl_sine_eval #(
   parameter int XW      = 10,
   parameter int CF      = 17,
   parameter int OF      = 16,
   parameter int OUT_REG = 0,
   localparam int NSEG   = pwl_sine_pkg::SEGS,
   localparam int IW     = $clog2(NSEG),
   localparam int OUT_W  = OF + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [XW-1:0]    in_x,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_y,
   output logic [IW-1:0]    out_seg
);
   localparam int CW = CF + 1;
   localparam int PW = CW + XW;
   localparam int D  = CF + XW - OF;
   localparam int DB = CF - OF;
   localparam int SW = OF + 2;
   localparam logic [PW:0] PHALF = (PW+1)'(1) << (D - 1);
   localparam logic [CW:0] BHALF = (CW+1)'(1) << (DB - 1);

   generate
      if (XW < 2 || OF < 2) begin : g_bad_w
         $error("pwl_sine_eval: input and output need at least two bits");
      end
      if (CF <= OF) begin : g_bad_cf
         $error("pwl_sine_eval: coefficients must be finer than the output");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_oreg
         $error("pwl_sine_eval: OUT_REG must be 0 or 1");
      end
   endgenerate

   logic [IW-1:0] seg_c;
   logic [CW-1:0] a_c, b_c;
   logic [PW-1:0] prod_c;

   pwl_seg_locate #(.XW(XW), .NSEG(NSEG), .IW(IW)) u_loc (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (in_valid),
      .x_i   (in_x),
      .seg_o (seg_c)
   );

   pwl_coef_rom #(.NSEG(NSEG), .IW(IW), .CF(CF), .CW(CW)) u_rom (
      .seg_i   (seg_c),
      .slope_o (a_c),
      .icpt_o  (b_c)
   );

   assign prod_c = {{XW{1'b0}}, a_c} * {{CW{1'b0}}, in_x};

   // register after the multiplier
   logic          vld_q;
   logic [PW-1:0] prod_q;
   logic [CW-1:0] b_q;
   logic [IW-1:0] seg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         prod_q <= '0;
         b_q    <= '0;
         seg_q  <= '0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            prod_q <= prod_c;
            b_q    <= b_c;
            seg_q  <= seg_c;
         end
      end
   end

   // round product and intercept to the output grid, then add
   logic [SW-1:0] p_rnd, b_rnd, sum_c;

   assign p_rnd = SW'(({1'b0, prod_q} + PHALF) >> D);
   assign b_rnd = SW'(({1'b0, b_q} + BHALF) >> DB);
   assign sum_c = p_rnd + b_rnd;

   generate
      if (OUT_REG == 0) begin : g_direct
         assign out_valid = vld_q;
         assign out_y     = sum_c[OUT_W-1:0];
         assign out_seg   = seg_q;

         // R1
         lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         // R8
         idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
      end else begin : g_staged
         logic             vld_r;
         logic [OUT_W-1:0] y_r;
         logic [IW-1:0]    seg_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_r <= 1'b0;
               y_r   <= '0;
               seg_r <= '0;
            end else begin
               vld_r <= vld_q;
               if (vld_q) begin
                  y_r   <= sum_c[OUT_W-1:0];
                  seg_r <= seg_q;
               end
            end
         end
         assign out_valid = vld_r;
         assign out_y     = y_r;
         assign out_seg   = seg_r;

         // R1
         lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> ##1 out_valid);
         // R8
         idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ##1 !out_valid);
      end
   endgenerate

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> !sum_c[SW-1]);

endmodule

// File: tb/sim_pwl_sine_eval.sv
`timescale 1ns/1ps
module sim_pwl_sine_eval;
   localparam int XW = 10;
   localparam int OF = 16;
   localparam real TOL = 0.0015;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [9:0]  in_x = '0;
   logic        out_valid;
   logic [16:0] out_y;
   logic [3:0]  out_seg;

   int checks = 0;
   int fails  = 0;
   logic       pv = 1'b0;
   logic [9:0] px = '0;

   always #4 clk = ~clk;

   pwl_sine_eval #(.XW(XW), .CF(17), .OF(OF), .OUT_REG(0)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
      .out_valid(out_valid), .out_y(out_y), .out_seg(out_seg)
   );

   function automatic int bnd(input int k);
      case (k)
         0: return 205;  1: return 334;  2: return 444;
         3: return 543;  4: return 636;  5: return 724;
         6: return 809;  7: return 892;  default: return 974;
      endcase
   endfunction

   function automatic int exp_seg(input int xv);
      int n = 0;
      for (int k = 0; k < 9; k++) if (xv >= bnd(k)) n++;
      return n;
   endfunction

   function automatic bit on_edge(input int xv);
      for (int k = 0; k < 9; k++) if (xv == bnd(k)) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit below_edge(input int xv);
      for (int k = 0; k < 9; k++) if (xv == bnd(k) - 1) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check_out();
      real r, d;
      checks++;
      if (out_valid !== pv) begin
         fails++;
         $display("FAIL %s out_valid=%0b expected %0b", pv ? "R1" : "R8", out_valid, pv);
      end
      if (pv) begin
         checks++;
         if (out_seg !== 4'(exp_seg(int'(px)))) begin
            fails++;
            if (on_edge(int'(px)))
               $display("FAIL R4 x=%0d seg=%0d expected %0d", px, out_seg, exp_seg(int'(px)));
            else if (below_edge(int'(px)))
               $display("FAIL R2 x=%0d seg=%0d expected %0d", px, out_seg, exp_seg(int'(px)));
            else
               $display("FAIL R3 x=%0d seg=%0d expected %0d", px, out_seg, exp_seg(int'(px)));
         end
         r = $sin(3.14159265358979 * real'(px) / 2048.0);
         d = real'(out_y) / 65536.0 - r;
         if (d < 0.0) d = -d;
         checks++;
         if (d > TOL || $isunknown(out_y)) begin
            fails++;
            $display("FAIL R5 R6 x=%0d y=%0d expected %0d (+/-%0d)", px, out_y,
                     $rtoi(r * 65536.0 + 0.5), $rtoi(TOL * 65536.0));
         end
         if (px == 10'd0) begin
            checks++;
            if (out_y !== 17'd65) begin
               fails++;
               $display("FAIL R7 y=%0d expected 65", out_y);
            end
         end
      end
   endtask

   task automatic step(input logic v, input logic [9:0] xv);
      @(negedge clk);
      check_out();
      in_valid = v;
      in_x     = xv;
      pv       = v;
      px       = xv;
   endtask

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd2718);
      // R9: reset state
      repeat (3) begin
         @(negedge clk);
         checks++;
         if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9 out_valid=%0b expected 0", out_valid);
         end
      end
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b0, 10'd0);
      step(1'b0, 10'd0);
      // exhaustive back-to-back sweep
      for (int i = 0; i < 1024; i++) step(1'b1, 10'(i));
      step(1'b0, 10'd0);
      // directed boundary pairs
      for (int k = 0; k < 9; k++) begin
         step(1'b1, 10'(bnd(k) - 1));
         step(1'b1, 10'(bnd(k)));
         step(1'b0, 10'(bnd(k)));
      end
      step(1'b1, 10'd0);
      step(1'b1, 10'd1023);
      // random traffic with gaps
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 10) < 7, 10'($urandom));
      end
      step(1'b0, 10'd0);
      step(1'b0, 10'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule